// File: doc/BRIEF.md
# Configurable FIFO Status Pin Selector

This block drives three general-purpose status pins for a packet radio datapath. Each pin has its own 6-bit selection code and an invert bit. The code picks one of eight FIFO and packet status flags, a fixed level, or a high-impedance state. The flags are built from the fill levels of the receive and transmit FIFOs, a programmable threshold for each FIFO, and single-cycle event strobes from the packet engine: sync detected, end of packet, CRC good, address-check failure, FIFO writes and reads, and flushes. Each flag sets and clears on its own rule. Some follow a level. Some are sticky until a flush. Some clear on a packet or read event.

The FIFOs, the radio and the CRC engine are outside the block and appear only as inputs. All flags are registered on the system clock and reset synchronously. The pin multiplexer is combinational from the flag registers and the configuration. A change in an input therefore reaches a pin one clock later, while a change of selection code or invert bit shows at once. Every port is a plain level or strobe. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `status_pin_mux`

## Requirements
- R1: Code 0 drives 1 in the cycle after `rx_level >= rx_thresh` and 0 in the cycle after `rx_level < rx_thresh`.
- R2: Code 1 sets in the cycle after `rx_level >= rx_thresh` or an `eop` strobe. It clears only in the cycle after `rx_level == 0` with neither set cause present, and otherwise holds.
- R3: Code 2 drives 1 in the cycle after `tx_level >= tx_thresh` and 0 in the cycle after `tx_level < tx_thresh`.
- R4: Code 3 sets in the cycle after `tx_level == FIFO_DEPTH`. It clears in the cycle after `tx_level < tx_thresh` and otherwise holds.
- R5: Code 4 is a sticky receive-overflow flag. It sets after `rx_wr` while `rx_level == FIFO_DEPTH` and stays set until `rx_flush`. When both occur in the same cycle, the flush wins.
- R6: Code 5 is a sticky transmit-underflow flag. It sets after `tx_rd` while `tx_level == 0` and stays set until `tx_flush`. When both occur in the same cycle, the flush wins.
- R7: Code 6 sets after `sync_det` and clears after `eop`. With `tx_mode = 0` it also clears after `addr_fail` or a receive overflow event. With `tx_mode = 1` it also clears after a transmit underflow event. A clear wins over a set.
- R8: Code 7 sets after `eop` with `crc_good` while `tx_mode = 0`. It clears after `rx_read` and otherwise holds. A set wins over a read in the same cycle.
- R9: Code 0x2E drives `pin_oe = 0` and `pin_out = 0`. Code 0x2F drives `pin_out` equal to the pin's invert bit.
- R10: Every code except 0x2E drives `pin_oe = 1`, and `pin_out` is the selected source XOR the invert bit. Codes 8 to 0x2D and 0x30 to 0x3F select a constant 0 source.
- R11: While `rst` is high at a clock edge, all eight flags clear. The code for pin i is `pin_sel[6*i+5:6*i]` and its invert bit is `pin_inv[i]`. A change of code or invert bit reaches the pins in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_sel | input | 18 | Selection codes, 6 bits per pin, pin 0 in the low bits |
| pin_inv | input | 3 | Invert bit per pin |
| rx_level | input | 7 | Receive FIFO fill count |
| tx_level | input | 7 | Transmit FIFO fill count |
| rx_thresh | input | 7 | Receive FIFO threshold |
| tx_thresh | input | 7 | Transmit FIFO threshold |
| rx_wr | input | 1 | Receive FIFO write strobe |
| rx_read | input | 1 | Receive FIFO byte-read strobe |
| tx_rd | input | 1 | Transmit FIFO read strobe |
| rx_flush | input | 1 | Receive FIFO flush strobe |
| tx_flush | input | 1 | Transmit FIFO flush strobe |
| sync_det | input | 1 | Sync word sent or received |
| eop | input | 1 | End of packet |
| crc_good | input | 1 | CRC matched, qualified by `eop` |
| addr_fail | input | 1 | Address check failed |
| tx_mode | input | 1 | 1 while transmitting, 0 while receiving |
| pin_out | output | 3 | Pin output values |
| pin_oe | output | 3 | Pin drive enables, 0 = high impedance |

## Verification
The assertions check on every cycle the properties that hold in a single step. These are the clears caused by a level dropping below threshold, the sticky hold and flush-clear of both error flags, the end-of-packet clear of the packet flag, the read clear of the CRC flag, and the fixed and high-impedance pin codes. Other behaviour only shows up when inputs are ordered over several cycles, and only the bench's scenarios exercise it. Examples are a flag that stays set while the receive level drains between threshold and empty, the transmit-full flag holding through the hysteresis band, and the different kill conditions of the packet flag in receive and transmit mode. The same applies to same-cycle races such as flush with overflow and read with a new CRC result.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int CODE_W    = 6;
  localparam int NUM_FLAGS = 8;

  typedef logic [CODE_W-1:0] sel_code_t;

  localparam sel_code_t CODE_HIZ   = 6'h2E;
  localparam sel_code_t CODE_FIXED = 6'h2F;

  // flag indices equal the selection code that picks them
  localparam int FL_RX_THR  = 0;
  localparam int FL_RX_DATA = 1;
  localparam int FL_TX_THR  = 2;
  localparam int FL_TX_FULL = 3;
  localparam int FL_RX_OVF  = 4;
  localparam int FL_TX_UNF  = 5;
  localparam int FL_PKT     = 6;
  localparam int FL_CRC     = 7;
endpackage

// File: rtl/spm_level_flags.sv
module spm_level_flags #(
  parameter int FIFO_DEPTH = 64,
  parameter int LW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_thresh,
  input  logic [LW-1:0] tx_thresh,
  input  logic          eop,
  output logic [3:0]    lvl_flags
);
  localparam logic [LW-1:0] FULL = LW'(FIFO_DEPTH);

  logic rx_ge, tx_ge, rx_empty, tx_full;
  logic [3:0] q;

  assign rx_ge    = (rx_level >= rx_thresh);
  assign tx_ge    = (tx_level >= tx_thresh);
  assign rx_empty = (rx_level == '0);
  assign tx_full  = (tx_level == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q[0] <= rx_ge;
      if (rx_ge || eop)  q[1] <= 1'b1;
      else if (rx_empty) q[1] <= 1'b0;
      q[2] <= tx_ge;
      if (tx_full)       q[3] <= 1'b1;
      else if (!tx_ge)   q[3] <= 1'b0;
    end
  end

  assign lvl_flags = q;

  assert_rx_below_R1: assert property (@(posedge clk) disable iff (rst)
    (rx_level < rx_thresh) |=> !lvl_flags[0]);
  assert_rx_drained_R2: assert property (@(posedge clk) disable iff (rst)
    (rx_level == '0 && rx_thresh != '0 && !eop) |=> !lvl_flags[1]);
  assert_tx_below_R3: assert property (@(posedge clk) disable iff (rst)
    (tx_level < tx_thresh) |=> !lvl_flags[2]);
  assert_tx_full_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_level == FULL) |=> lvl_flags[3]);
endmodule

// File: rtl/spm_event_flags.sv
module spm_event_flags #(
  parameter int FIFO_DEPTH = 64,
  parameter int LW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  input  logic          rx_wr,
  input  logic          rx_read,
  input  logic          tx_rd,
  input  logic          rx_flush,
  input  logic          tx_flush,
  input  logic          sync_det,
  input  logic          eop,
  input  logic          crc_good,
  input  logic          addr_fail,
  input  logic          tx_mode,
  output logic [3:0]    evt_flags
);
  localparam logic [LW-1:0] FULL = LW'(FIFO_DEPTH);

  logic ovf_ev, unf_ev, pkt_kill, crc_set;
  logic ovf_q, unf_q, pkt_q, crc_q;

  assign ovf_ev   = rx_wr && (rx_level == FULL);
  assign unf_ev   = tx_rd && (tx_level == '0);
  assign pkt_kill = eop || (!tx_mode && (addr_fail || ovf_ev)) || (tx_mode && unf_ev);
  assign crc_set  = eop && crc_good && !tx_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      pkt_q <= 1'b0;
      crc_q <= 1'b0;
    end else begin
      if (rx_flush)      ovf_q <= 1'b0;
      else if (ovf_ev)   ovf_q <= 1'b1;
      if (tx_flush)      unf_q <= 1'b0;
      else if (unf_ev)   unf_q <= 1'b1;
      if (pkt_kill)      pkt_q <= 1'b0;
      else if (sync_det) pkt_q <= 1'b1;
      if (crc_set)       crc_q <= 1'b1;
      else if (rx_read)  crc_q <= 1'b0;
    end
  end

  assign evt_flags = {crc_q, pkt_q, unf_q, ovf_q};

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (evt_flags[0] && !rx_flush) |=> evt_flags[0]);
  assert_ovf_flush_R5: assert property (@(posedge clk) disable iff (rst)
    rx_flush |=> !evt_flags[0]);
  assert_unf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (evt_flags[1] && !tx_flush) |=> evt_flags[1]);
  assert_unf_flush_R6: assert property (@(posedge clk) disable iff (rst)
    tx_flush |=> !evt_flags[1]);
  assert_pkt_end_R7: assert property (@(posedge clk) disable iff (rst)
    eop |=> !evt_flags[2]);
  assert_crc_read_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_read && !eop) |=> !evt_flags[3]);
endmodule

// File: rtl/spm_pin_drive.sv
module spm_pin_drive
  import spm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  sel_code_t            sel,
  input  logic                 inv,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic                 pin_out,
  output logic                 pin_oe
);
  logic src;

  always_comb begin
    src = 1'b0;
    if (sel < sel_code_t'(NUM_FLAGS)) src = flags[sel[2:0]];
  end

  assign pin_oe  = (sel != CODE_HIZ);
  assign pin_out = pin_oe ? (src ^ inv) : 1'b0;

  assert_hiz_R9: assert property (@(posedge clk) disable iff (rst)
    (sel == CODE_HIZ) |-> (!pin_oe && !pin_out));
  assert_fixed_R9: assert property (@(posedge clk) disable iff (rst)
    (sel == CODE_FIXED) |-> (pin_out == inv));
  assert_driven_R10: assert property (@(posedge clk) disable iff (rst)
    (sel != CODE_HIZ) |-> pin_oe);
endmodule

// File: rtl/status_pin_mux.sv
module status_pin_mux
  import spm_pkg::*;
#(
  parameter int NUM_PINS   = 3,
  parameter int FIFO_DEPTH = 64,
  parameter int LW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PINS*CODE_W-1:0] pin_sel,
  input  logic [NUM_PINS-1:0]        pin_inv,
  input  logic [LW-1:0]              rx_level,
  input  logic [LW-1:0]              tx_level,
  input  logic [LW-1:0]              rx_thresh,
  input  logic [LW-1:0]              tx_thresh,
  input  logic                       rx_wr,
  input  logic                       rx_read,
  input  logic                       tx_rd,
  input  logic                       rx_flush,
  input  logic                       tx_flush,
  input  logic                       sync_det,
  input  logic                       eop,
  input  logic                       crc_good,
  input  logic                       addr_fail,
  input  logic                       tx_mode,
  output logic [NUM_PINS-1:0]        pin_out,
  output logic [NUM_PINS-1:0]        pin_oe
);
  logic [3:0] lvl_flags, evt_flags;
  logic [NUM_FLAGS-1:0] flags;

  spm_level_flags #(.FIFO_DEPTH(FIFO_DEPTH), .LW(LW)) u_lvl (
    .clk(clk), .rst(rst), .rx_level(rx_level), .tx_level(tx_level),
    .rx_thresh(rx_thresh), .tx_thresh(tx_thresh), .eop(eop),
    .lvl_flags(lvl_flags)
  );

  spm_event_flags #(.FIFO_DEPTH(FIFO_DEPTH), .LW(LW)) u_evt (
    .clk(clk), .rst(rst), .rx_level(rx_level), .tx_level(tx_level),
    .rx_wr(rx_wr), .rx_read(rx_read), .tx_rd(tx_rd),
    .rx_flush(rx_flush), .tx_flush(tx_flush), .sync_det(sync_det),
    .eop(eop), .crc_good(crc_good), .addr_fail(addr_fail),
    .tx_mode(tx_mode), .evt_flags(evt_flags)
  );

  assign flags = {evt_flags, lvl_flags};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    spm_pin_drive u_drv (
      .clk(clk), .rst(rst),
      .sel(pin_sel[p*CODE_W +: CODE_W]),
      .inv(pin_inv[p]),
      .flags(flags),
      .pin_out(pin_out[p]),
      .pin_oe(pin_oe[p])
    );
  end

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> ($countones(flags) == 0));
endmodule

// File: tb/status_pin_mux_tb_top.sv
module status_pin_mux_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [17:0] pin_sel = '0;
  logic [2:0]  pin_inv = '0;
  logic [6:0]  rx_level = '0, tx_level = '0, rx_thresh = 7'd8, tx_thresh = 7'd8;
  logic rx_wr = 0, rx_read = 0, tx_rd = 0, rx_flush = 0, tx_flush = 0;
  logic sync_det = 0, eop = 0, crc_good = 0, addr_fail = 0, tx_mode = 0;
  logic [2:0] pin_out, pin_oe;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit [7:0] mf;

  status_pin_mux dut_i (
    .clk(clk), .rst(rst), .pin_sel(pin_sel), .pin_inv(pin_inv),
    .rx_level(rx_level), .tx_level(tx_level), .rx_thresh(rx_thresh),
    .tx_thresh(tx_thresh), .rx_wr(rx_wr), .rx_read(rx_read), .tx_rd(tx_rd),
    .rx_flush(rx_flush), .tx_flush(tx_flush), .sync_det(sync_det),
    .eop(eop), .crc_good(crc_good), .addr_fail(addr_fail),
    .tx_mode(tx_mode), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference, one update per rising edge
  always @(posedge clk) begin
    int rl, tl, rt, tt;
    bit ovf, unf;
    rl = int'(rx_level); tl = int'(tx_level);
    rt = int'(rx_thresh); tt = int'(tx_thresh);
    ovf = rx_wr && rl == DEPTH;
    unf = tx_rd && tl == 0;
    if (rst) mf = '0;
    else begin
      mf[0] = rl >= rt;
      if (rl >= rt || eop) mf[1] = 1; else if (rl == 0) mf[1] = 0;
      mf[2] = tl >= tt;
      if (tl == DEPTH) mf[3] = 1; else if (tl < tt) mf[3] = 0;
      if (rx_flush) mf[4] = 0; else if (ovf) mf[4] = 1;
      if (tx_flush) mf[5] = 0; else if (unf) mf[5] = 1;
      if (eop || (!tx_mode && (addr_fail || ovf)) || (tx_mode && unf)) mf[6] = 0;
      else if (sync_det) mf[6] = 1;
      if (eop && crc_good && !tx_mode) mf[7] = 1; else if (rx_read) mf[7] = 0;
    end
  end

  function automatic string req_of(int code);
    case (code)
      0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
      4: return "R5"; 5: return "R6"; 6: return "R7"; 7: return "R8";
      46, 47: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic compare_all();
    for (int p = 0; p < 3; p++) begin
      int code;
      bit eo, ee;
      code = int'(pin_sel[p*6 +: 6]);
      ee = (code != 46);
      eo = ee ? (((code < 8) ? mf[code] : 1'b0) ^ pin_inv[p]) : 1'b0;
      checks++;
      if (pin_out[p] !== eo || pin_oe[p] !== ee) begin
        fails++;
        $display("FAIL %s pin%0d code=%0d out/oe actual=%b%b expected=%b%b at %0t",
                 req_of(code), p, code, pin_out[p], pin_oe[p], eo, ee, $time);
      end
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic expect_pin(int p, bit v, string req);
    checks++;
    if (pin_out[p] !== v) begin
      fails++;
      $display("FAIL %s pin%0d actual=%b expected=%b at %0t", req, p, pin_out[p], v, $time);
    end
  endtask

  task automatic set_codes(int c0, int c1, int c2, logic [2:0] inv);
    pin_sel = {6'(c2), 6'(c1), 6'(c0)};
    pin_inv = inv;
  endtask

  task automatic report();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    set_codes(0, 1, 2, 3'b000);
    step(2);
    // R11: reset state
    checks++;
    if (pin_out !== 3'b000 || pin_oe !== 3'b111) begin
      fails++;
      $display("FAIL R11 reset actual=%b/%b expected=000/111", pin_out, pin_oe);
    end
    rst = 0;
    step(1);

    // levels R1 R2 R3
    rx_level = 8; step(1);
    expect_pin(0, 1, "R1"); expect_pin(1, 1, "R2");
    rx_level = 7; step(1);
    expect_pin(0, 0, "R1"); expect_pin(1, 1, "R2");
    rx_level = 0; step(1);
    expect_pin(1, 0, "R2");
    rx_level = 2; eop = 1; step(1); eop = 0;
    expect_pin(1, 1, "R2");
    rx_level = 0; step(1);
    tx_level = 8; step(1);
    expect_pin(2, 1, "R3");
    tx_level = 3; step(1);
    expect_pin(2, 0, "R3");

    // R4 R5 R6
    set_codes(3, 4, 5, 3'b000);
    tx_level = 64; step(1); expect_pin(0, 1, "R4");
    tx_level = 20; step(2); expect_pin(0, 1, "R4");
    tx_level = 7;  step(1); expect_pin(0, 0, "R4");
    rx_level = 64; rx_wr = 1; step(1); rx_wr = 0;
    expect_pin(1, 1, "R5");
    rx_level = 10; step(5); expect_pin(1, 1, "R5");
    rx_level = 64; rx_wr = 1; rx_flush = 1; step(1); rx_wr = 0; rx_flush = 0;
    expect_pin(1, 0, "R5");
    tx_level = 0; tx_rd = 1; step(1); tx_rd = 0;
    expect_pin(2, 1, "R6");
    step(4); expect_pin(2, 1, "R6");
    tx_flush = 1; step(1); tx_flush = 0;
    expect_pin(2, 0, "R6");

    // R7 R8 R9
    rx_level = 4;
    set_codes(6, 7, 46, 3'b100);
    tx_mode = 0;
    sync_det = 1; step(1); sync_det = 0; expect_pin(0, 1, "R7");
    addr_fail = 1; step(1); addr_fail = 0; expect_pin(0, 0, "R7");
    sync_det = 1; step(1); sync_det = 0;
    eop = 1; crc_good = 1; step(1); eop = 0; crc_good = 0;
    expect_pin(0, 0, "R7"); expect_pin(1, 1, "R8");
    step(3); expect_pin(1, 1, "R8");
    rx_read = 1; step(1); rx_read = 0; expect_pin(1, 0, "R8");
    checks++;
    if (pin_oe[2] !== 1'b0) begin
      fails++; $display("FAIL R9 hiz oe actual=%b expected=0", pin_oe[2]);
    end
    tx_mode = 1; sync_det = 1; step(1); sync_det = 0; expect_pin(0, 1, "R7");
    addr_fail = 1; step(1); addr_fail = 0; expect_pin(0, 1, "R7");
    tx_level = 0; tx_rd = 1; step(1); tx_rd = 0; expect_pin(0, 0, "R7");
    tx_flush = 1; step(1); tx_flush = 0; tx_mode = 0;

    // R9 R10 fixed, reserved, inverted flag
    set_codes(47, 47, 21, 3'b110);
    step(1);
    expect_pin(0, 0, "R9"); expect_pin(1, 1, "R9"); expect_pin(2, 1, "R10");
    rx_level = 1; set_codes(0, 62, 0, 3'b001);
    step(1);
    expect_pin(0, 1, "R10"); expect_pin(1, 0, "R10"); expect_pin(2, 0, "R10");

    // R11 mid-run reset of sticky flag
    set_codes(4, 5, 1, 3'b000);
    rx_level = 64; rx_wr = 1; tx_level = 0; tx_rd = 1; step(1);
    rx_wr = 0; tx_rd = 0;
    expect_pin(0, 1, "R5");
    rst = 1; step(1); rst = 0;
    expect_pin(0, 0, "R11"); expect_pin(1, 0, "R11"); expect_pin(2, 0, "R11");

    // mixed stimulus against the reference
    for (int i = 0; i < 3000; i++) begin
      int pick[10] = '{0, 1, 2, 3, 4, 5, 6, 7, 46, 47};
      int r;
      if (i % 40 == 0) begin
        set_codes(pick[$urandom % 10], pick[$urandom % 10],
                  ($urandom % 5 == 0) ? 20 : pick[$urandom % 10], 3'($urandom));
        rx_thresh = 7'($urandom % 65);
        tx_thresh = 7'($urandom % 65);
      end
      r = $urandom % 4;
      rx_level = (r == 0) ? 7'd64 : (r == 1) ? 7'd0 : 7'($urandom % 65);
      r = $urandom % 4;
      tx_level = (r == 0) ? 7'd64 : (r == 1) ? 7'd0 : 7'($urandom % 65);
      rx_wr = ($urandom % 3 == 0); tx_rd = ($urandom % 3 == 0);
      rx_read = ($urandom % 6 == 0);
      rx_flush = ($urandom % 12 == 0); tx_flush = ($urandom % 12 == 0);
      sync_det = ($urandom % 5 == 0); eop = ($urandom % 7 == 0);
      crc_good = ($urandom % 2 == 0); addr_fail = ($urandom % 9 == 0);
      tx_mode = ($urandom % 2 == 0);
      rst = ($urandom % 300 == 0);
      step(1);
    end
    rst = 0;
    report();
  end
endmodule